// File: doc/BRIEF.md
# Event Block Accumulator with Readout Handshake

The block counts events that the capture path has finished storing and, once the count reaches a programmed block size, fires a one-cycle block-ready pulse toward the readout controller. After that pulse it disarms itself. No further block pulses are generated, and no further events are counted, until the readout controller returns an acknowledge saying the block has been drained. The acknowledge clears the event count and re-arms the block for the next block.

The `armed` output lets upstream trigger logic hold off new captures while a full block waits to be read. An event strobe that arrives anyway during that wait is dropped and recorded in a sticky overflow flag that only reset clears. The block size input is eight bits wide, so a block holds at most 255 events. A size of zero behaves as a size of one.

Top module: `ebk_accum`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `evt_count_o` is 0, `armed_o` is 1, `data_trig_o` is 0 and `overflow_o` is 0.
- R2: A high `evt_stored_i` sampled while `armed_o` is 1 raises `evt_count_o` by exactly one in the next cycle.
- R3: When a counted strobe brings the count to a value greater than or equal to the effective block size, `data_trig_o` is 1 for exactly one cycle, in the cycle after that strobe. In that same cycle `evt_count_o` shows the new count.
- R4: A `blk_size_i` value of 0 acts as a block size of 1: every counted strobe then fires `data_trig_o`.
- R5: In the cycle after `data_trig_o` fires, `armed_o` is 0. While `armed_o` is 0, strobes change neither `evt_count_o` nor `data_trig_o`.
- R6: A strobe sampled while `armed_o` is 0 sets `overflow_o` in the next cycle. `overflow_o` then stays 1 until reset.
- R7: A high `rd_ack_i` sampled while `armed_o` is 0 gives `evt_count_o` = 0 and `armed_o` = 1 in the next cycle. A strobe in that same cycle is not counted.
- R8: A high `rd_ack_i` sampled while `armed_o` is 1 has no effect on `evt_count_o` or `armed_o`.
- R9: The size comparison is greater-or-equal. If `blk_size_i` is lowered below the current count mid-block, the next counted strobe fires `data_trig_o`. A size of 255 fires on the 255th event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_stored_i | input | 1 | One-cycle strobe per stored event |
| blk_size_i | input | 8 | Events per block (0 acts as 1) |
| rd_ack_i | input | 1 | Readout-complete acknowledge |
| data_trig_o | output | 1 | One-cycle block-ready pulse |
| armed_o | output | 1 | 1 while strobes are counted, 0 while waiting for acknowledge |
| evt_count_o | output | 8 | Events counted in the current block |
| overflow_o | output | 1 | Sticky flag: a strobe arrived while waiting |

## Verification
The assertions assume a synchronous reset of at least one cycle and inputs that change only between clock edges. They place no restriction on `blk_size_i` changing during a block, or on strobes and acknowledges arriving together or out of turn. The stimulus therefore drives every input on the falling edge. It keeps reset asserted for several cycles and deliberately mixes mid-block size changes, strobes during the wait, simultaneous strobe and acknowledge, and stray acknowledges while armed.

// File: rtl/ebk_pkg.sv
package ebk_pkg;
  typedef enum logic {
    ST_ARMED = 1'b0,
    ST_WAIT  = 1'b1
  } ebk_state_t;
endpackage

// File: rtl/ebk_size_norm.sv
module ebk_size_norm #(
  parameter int CNT_W = 8
) (
  input  logic [CNT_W-1:0] size_i,
  output logic [CNT_W-1:0] eff_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // R4: zero is promoted to a block of one event
  always_comb begin
    eff_o = (size_i == '0) ? ONE : size_i;
  end
endmodule

// File: rtl/ebk_counter.sv
module ebk_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] count_o,
  output logic             reach_o
);
  localparam int EXT_W = CNT_W + 1;

  logic [EXT_W-1:0] next_ext;

  // widened so an increment past the top cannot wrap below the limit (R9)
  always_comb begin
    next_ext = {1'b0, count_o} + EXT_W'(1);
    reach_o  = next_ext >= {1'b0, limit_i};
  end

  always_ff @(posedge clk) begin
    if (rst)        count_o <= '0;
    else if (clr_i) count_o <= '0;
    else if (inc_i) count_o <= next_ext[CNT_W-1:0];
  end

  assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (count_o == '0));
endmodule

// File: rtl/ebk_ctrl.sv
module ebk_ctrl
  import ebk_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic evt_i,
  input  logic ack_i,
  input  logic reach_i,
  output logic inc_o,
  output logic clr_o,
  output logic trig_o,
  output logic armed_o,
  output logic ovf_o
);
  ebk_state_t state_q;
  logic       fire;

  always_comb begin
    inc_o = evt_i && (state_q == ST_ARMED);
    fire  = inc_o && reach_i;
    clr_o = ack_i && (state_q == ST_WAIT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_ARMED;
      trig_o  <= 1'b0;
      ovf_o   <= 1'b0;
    end else begin
      trig_o <= fire;
      if (evt_i && state_q == ST_WAIT) ovf_o <= 1'b1;
      case (state_q)
        ST_ARMED: if (fire)  state_q <= ST_WAIT;
        ST_WAIT:  if (ack_i) state_q <= ST_ARMED;
        default:             state_q <= ST_ARMED;
      endcase
    end
  end

  assign armed_o = (state_q == ST_ARMED);

  assert_trig_single_R3: assert property (@(posedge clk) disable iff (rst)
    trig_o |=> !trig_o);
  assert_trig_disarms_R5: assert property (@(posedge clk) disable iff (rst)
    trig_o |-> !armed_o);
  assert_ovf_cause_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_o) |-> $past(evt_i && !armed_o));
  assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> !$fell(ovf_o));
endmodule

// File: rtl/ebk_accum.sv
module ebk_accum #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt_stored_i,
  input  logic [CNT_W-1:0] blk_size_i,
  input  logic             rd_ack_i,
  output logic             data_trig_o,
  output logic             armed_o,
  output logic [CNT_W-1:0] evt_count_o,
  output logic             overflow_o
);
  logic [CNT_W-1:0] eff_size;
  logic             inc, clr, reach;

  ebk_size_norm #(.CNT_W(CNT_W)) size_i (
    .size_i (blk_size_i),
    .eff_o  (eff_size)
  );

  ebk_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk     (clk),
    .rst     (rst),
    .inc_i   (inc),
    .clr_i   (clr),
    .limit_i (eff_size),
    .count_o (evt_count_o),
    .reach_o (reach)
  );

  ebk_ctrl ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .evt_i   (evt_stored_i),
    .ack_i   (rd_ack_i),
    .reach_i (reach),
    .inc_o   (inc),
    .clr_o   (clr),
    .trig_o  (data_trig_o),
    .armed_o (armed_o),
    .ovf_o   (overflow_o)
  );

  assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
    (armed_o && evt_stored_i) |=> (evt_count_o == $past(evt_count_o) + CNT_W'(1)));
  assert_zero_size_R4: assert property (@(posedge clk) disable iff (rst)
    (armed_o && evt_stored_i && blk_size_i == '0) |=> data_trig_o);
  assert_wait_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!armed_o && !rd_ack_i) |=> ($stable(evt_count_o) && !data_trig_o && !armed_o));
  assert_rearm_R7: assert property (@(posedge clk) disable iff (rst)
    (!armed_o && rd_ack_i) |=> (armed_o && evt_count_o == '0));
  assert_ack_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (armed_o && rd_ack_i && !evt_stored_i) |=> ($stable(evt_count_o) && armed_o));
endmodule

// File: tb/ebk_accum_tb.sv
`timescale 1ns/1ps
module ebk_accum_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       evt, ack;
  logic [7:0] sz;
  logic       trig, armed, ovf;
  logic [7:0] cnt;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // model state
  int  m_cnt;
  bit  m_armed, m_trig, m_ovf;

  always #2 clk = ~clk;

  ebk_accum dut_i (
    .clk(clk), .rst(rst), .evt_stored_i(evt), .blk_size_i(sz),
    .rd_ack_i(ack), .data_trig_o(trig), .armed_o(armed),
    .evt_count_o(cnt), .overflow_o(ovf)
  );

  function automatic int eff(input int s);
    return (s == 0) ? 1 : s;
  endfunction

  task automatic chk(input string req, input int act, input int exp_v, input string what);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp_v);
    end
  endtask

  task automatic model_step(input bit e, input bit a, input int s);
    m_trig = 1'b0;
    if (m_armed) begin
      if (e) begin
        m_cnt++;
        if (m_cnt >= eff(s)) begin
          m_trig  = 1'b1;
          m_armed = 1'b0;
        end
      end
    end else begin
      if (e) m_ovf = 1'b1;
      if (a) begin
        m_cnt   = 0;
        m_armed = 1'b1;
      end
    end
  endtask

  task automatic cyc(input bit e, input bit a, input int s, input string req);
    @(negedge clk);
    evt = e; ack = a; sz = 8'(s);
    model_step(e, a, s);
    @(posedge clk);
    #1;
    chk(req, cnt,   m_cnt,   "count");
    chk(req, armed, m_armed, "armed");
    chk(req, trig,  m_trig,  "trig");
    chk(req, ovf,   m_ovf,   "overflow");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; evt = 1'b0; ack = 1'b0;
    repeat (3) @(negedge clk);
    m_cnt = 0; m_armed = 1'b1; m_trig = 1'b0; m_ovf = 1'b0;
    chk("R1", cnt, 0, "count"); chk("R1", armed, 1, "armed");
    chk("R1", trig, 0, "trig"); chk("R1", ovf, 0, "overflow");
    rst = 1'b0;
    @(posedge clk); #1;
    chk("R1", cnt, 0, "count"); chk("R1", armed, 1, "armed");
  endtask

  initial begin
    int seed;
    int rsz;
    rst = 1'b1; evt = 1'b0; ack = 1'b0; sz = 8'd3;
    do_reset();
    // R2 / R3: block of 3
    cyc(1, 0, 3, "R2");
    cyc(0, 0, 3, "R2");
    cyc(1, 0, 3, "R2");
    cyc(1, 0, 3, "R3");
    cyc(0, 0, 3, "R3");
    // R5 / R6: strobes during wait are dropped and flagged
    cyc(1, 0, 3, "R5");
    cyc(1, 0, 3, "R6");
    // R7: ack with simultaneous strobe
    cyc(1, 1, 3, "R7");
    cyc(0, 0, 3, "R6");
    // R8: ack while armed
    cyc(1, 0, 3, "R2");
    cyc(0, 1, 3, "R8");
    // R9: lower size below count
    cyc(1, 0, 9, "R2");
    cyc(1, 0, 1, "R9");
    cyc(0, 1, 1, "R7");
    // R4: size zero
    cyc(1, 0, 0, "R4");
    cyc(0, 1, 0, "R7");
    cyc(1, 0, 0, "R4");
    cyc(0, 1, 0, "R7");
    // R1 again after overflow set
    do_reset();
    // R9: size 255
    for (int i = 0; i < 255; i++) cyc(1, 0, 255, (i == 254) ? "R9" : "R2");
    cyc(0, 0, 255, "R5");
    cyc(0, 1, 255, "R7");
    // random mix
    seed = $urandom(32'd20240611);
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      rsz = (r < 5) ? 0 : (r < 10) ? $urandom_range(0, 255) : $urandom_range(1, 6);
      cyc($urandom_range(0, 99) < 55, $urandom_range(0, 99) < 20, rsz, "R3");
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule